// File: doc/BRIEF.md
# Two-Level Cache Tag Hit Detector

This block decides whether a 22-bit requested address is present in a two-level cache. It keeps only tags and holds no data. There are two tag banks, a first level and a second level, and each bank has one entry per index. A valid bit guards each entry, and reset clears all valid bits. A 10-bit index counter advances on every clock and wraps at its top value. The value the counter holds when a request is accepted is the bank index that the lookup uses.

Only one lookup is in flight at a time. The first-level bank is checked first. If the first level misses, the second-level bank is checked. A second-level hit copies the tag into the first level at the same index. A miss in both levels writes the tag into the second level. Each lookup ends with a one-cycle `done` pulse, and exactly one result flag is high during that pulse.

The controller is a four-state machine:
- `ST_IDLE` waits for `req_valid`. When it sees one, it latches the address and the counter value and moves to `ST_L1`.
- `ST_L1` checks the first-level bank. On a hit it moves to `ST_DONE`. On a miss it moves to `ST_L2`.
- `ST_L2` checks the second-level bank, makes the write that the result calls for, and moves to `ST_DONE`.
- `ST_DONE` drives the result for one cycle and always returns to `ST_IDLE`.

Top module: `cache_tag_lookup2`

## Requirements
- R1: Reset clears every valid bit in both banks and drives `done`, `l1_hit`, `l2_hit` and `miss` low. The first lookup at any index after reset reports `miss`.
- R2: The index counter starts at 0 when reset ends, advances by one on every clock, and wraps from 1023 to 0. A lookup uses the counter value present on the clock edge that accepts the request. The same address presented at a different index is looked up independently.
- R3: If the first-level bank holds a valid, equal tag at the lookup index, `done` and `l1_hit` are high in the second cycle after the accepting edge.
- R4: If the first level misses and the second-level bank holds a valid, equal tag, `done` and `l2_hit` are high in the third cycle after the accepting edge. The tag is also written into the first-level bank at that index.
- R5: If both levels miss, `done` and `miss` are high in the third cycle after the accepting edge. The tag is written into the second-level bank only, and the first-level bank is left unchanged.
- R6: `done` lasts exactly one cycle per accepted request. While `done` is high, exactly one of `l1_hit`, `l2_hit` and `miss` is high. While `done` is low, all three are low.
- R7: `req_valid` and `req_addr` are ignored from the accepting edge until one cycle after `done`. The next request can be accepted on the edge after the cycle that follows `done`.
- R8: A hit requires all 22 address bits to match the stored tag. A difference in any single bit, lowest or highest, is a miss at that level.
- R9: Writes overwrite an entry directly. A miss replaces the second-level tag at its index, and a second-level hit replaces the first-level tag at its index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled only while the block is idle |
| req_addr | input | 22 | Address to look up |
| l1_hit | output | 1 | Result flag, high with `done`: hit in the first level |
| l2_hit | output | 1 | Result flag, high with `done`: hit in the second level |
| miss | output | 1 | Result flag, high with `done`: hit in neither level |
| done | output | 1 | One-cycle end-of-lookup pulse |

## Verification
The hardest condition to create from the ports is a repeated lookup of one address at the same index. The index comes from a free-running counter, so an address meets its earlier entry only if the request is accepted exactly 1024 cycles apart, or at some multiple of that.

The stimulus keeps its own copy of the counter and holds each request back until the counter reaches a chosen index. This makes it possible to walk one index through the full sequence: miss, then second-level hit, then first-level hit, then replacement by a tag that differs in one bit.

A phase with randomized timing and back-to-back requests then runs against a behavioural model that is compared on every clock. That phase also covers requests held high, with a changed address, while a lookup is busy.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DONE = 2'd3
    } lk_state_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_L1   = 2'd1,
        RES_L2   = 2'd2,
        RES_MISS = 2'd3
    } lk_result_e;

endpackage

// File: rtl/tag_index_ctr.sv
module tag_index_ctr #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end

    // R2: the index steps by exactly one (modulo wrap) on every clock
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> idx == $past(idx) + 1'b1);

endmodule

// File: rtl/tag_bank.sv
module tag_bank #(
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_tag,
    output logic              rd_valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_tag
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] tags [DEPTH];
    logic [DEPTH-1:0]  vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tags[rd_idx];
    assign rd_valid = vld[rd_idx];

    // R9: a write is visible, valid and exact, on the following cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld[$past(wr_idx)] && tags[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/cache_tag_lookup2.sv
module cache_tag_lookup2
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              l1_hit,
    output logic              l2_hit,
    output logic              miss,
    output logic              done
);

    lk_state_e          state, nxt;
    lk_result_e         res_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   ctr_idx;

    logic [ADDR_W-1:0]  l1_tag, l2_tag;
    logic               l1_vld, l2_vld;
    logic               l1_match, l2_match;
    logic               l1_wr, l2_wr;

    tag_index_ctr #(.IDX_W(IDX_W)) u_ctr (
        .clk (clk),
        .rst (rst),
        .idx (ctr_idx)
    );

    tag_bank #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_l1 (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx_q),
        .rd_tag   (l1_tag),
        .rd_valid (l1_vld),
        .wr_en    (l1_wr),
        .wr_idx   (idx_q),
        .wr_tag   (addr_q)
    );

    tag_bank #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_l2 (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx_q),
        .rd_tag   (l2_tag),
        .rd_valid (l2_vld),
        .wr_en    (l2_wr),
        .wr_idx   (idx_q),
        .wr_tag   (addr_q)
    );

    assign l1_match = l1_vld && (l1_tag == addr_q);
    assign l2_match = l2_vld && (l2_tag == addr_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // request capture and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            idx_q  <= '0;
            res_q  <= RES_NONE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        idx_q  <= ctr_idx;
                    end
                end
                ST_L1: begin
                    if (l1_match) begin
                        res_q <= RES_L1;
                    end
                end
                ST_L2: begin
                    res_q <= l2_match ? RES_L2 : RES_MISS;
                end
                ST_DONE: begin
                    res_q <= RES_NONE;
                end
                default: begin
                    res_q <= RES_NONE;
                end
            endcase
        end
    end

    // next state and bank writes
    always_comb begin
        nxt   = state;
        l1_wr = 1'b0;
        l2_wr = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_L1;
            ST_L1:   nxt = l1_match ? ST_DONE : ST_L2;
            ST_L2: begin
                nxt   = ST_DONE;
                l1_wr = l2_match;
                l2_wr = !l2_match;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done   = (state == ST_DONE);
        l1_hit = done && (res_q == RES_L1);
        l2_hit = done && (res_q == RES_L2);
        miss   = done && (res_q == RES_MISS);
    end

    // R6: exactly one flag with done
    p_one_flag_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones({l1_hit, l2_hit, miss}) == 1);

    // R6: flags quiet without done
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> !(l1_hit || l2_hit || miss));

    // R6: done is a single-cycle pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the latched request is frozen while a lookup is in flight
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> ($stable(addr_q) && $stable(idx_q)));

    // R3: a first-level match reports l1_hit on the next cycle
    p_l1_first_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_L1 && l1_match) |=> (done && l1_hit));

    // R4/R5: second-level lookup resolves on the next cycle
    p_l2_resolve_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_L2) |=> (done && (l2_hit || miss)));

endmodule

// File: tb/tb_cache_tag_lookup2.sv
`timescale 1ns/1ps
module tb_cache_tag_lookup2;

    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [21:0] req_addr = '0;
    logic        l1_hit, l2_hit, miss, done;

    int tests_run = 0;
    int tests_failed = 0;

    cache_tag_lookup2 dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .l1_hit    (l1_hit),
        .l2_hit    (l2_hit),
        .miss      (miss),
        .done      (done)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    bit [21:0] l1m [int];
    bit [21:0] l2m [int];
    int cyc = 0;
    int done_at = -10;
    int exp_kind = 0;

    always @(posedge clk) begin
        if (rst) begin
            cyc = 0;
            done_at = -10;
            l1m.delete();
            l2m.delete();
        end else begin
            if (req_valid && cyc > done_at + 1) begin
                int ix;
                ix = cyc % DEPTH;
                if (l1m.exists(ix) && l1m[ix] == req_addr) begin
                    exp_kind = 1; done_at = cyc + 1;
                end else if (l2m.exists(ix) && l2m[ix] == req_addr) begin
                    exp_kind = 2; done_at = cyc + 2; l1m[ix] = req_addr;
                end else begin
                    exp_kind = 3; done_at = cyc + 2; l2m[ix] = req_addr;
                end
            end
            cyc = cyc + 1;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [3:0] expv, actv;
        actv = {done, l1_hit, l2_hit, miss};
        if (rst) begin
            expv = 4'b0000;
        end else if (cyc - 1 == done_at) begin
            expv = {1'b1, exp_kind == 1, exp_kind == 2, exp_kind == 3};
        end else begin
            expv = 4'b0000;
        end
        tests_run++;
        if (actv != expv) begin
            tests_failed++;
            $display("FAIL R6/R3/R4/R5 cycle %0d: {done,l1,l2,miss} actual %b expected %b",
                     cyc, actv, expv);
        end
    end

    // issue a request at counter index tgt (-1: next possible cycle)
    task automatic issue(input logic [21:0] a, input int tgt, input int expk,
                         input bit swap, input string req);
        int g;
        @(negedge clk);
        @(negedge clk);
        if (tgt >= 0) begin
            while (cyc % DEPTH != tgt) @(negedge clk);
        end
        req_valid = 1'b1;
        req_addr  = a;
        g = 0;
        do begin
            @(negedge clk);
            if (swap) req_addr = a ^ 22'h2AAAAA;
            g++;
        end while (!done && g < 10);
        if (expk != 0) begin
            logic [2:0] e, r;
            e = {expk == 1, expk == 2, expk == 3};
            r = {l1_hit, l2_hit, miss};
            tests_run++;
            if (!done || r != e) begin
                tests_failed++;
                $display("FAIL %s addr %h idx %0d: {done,l1,l2,miss} actual %b%b expected 1%b",
                         req, a, tgt, done, r, e);
            end
        end
        req_valid = 1'b0;
    endtask

    localparam logic [21:0] A = 22'h1234A5;

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low during reset
        tests_run++;
        if ({done, l1_hit, l2_hit, miss} != 4'b0) begin
            tests_failed++;
            $display("FAIL R1 reset outputs actual %b expected 0000", {done, l1_hit, l2_hit, miss});
        end
        rst = 1'b0;

        issue(A, 5, 3, 0, "R1 first lookup");
        issue(A, 5, 2, 0, "R4 second-level hit");
        issue(A, 5, 1, 0, "R3 first-level hit after copy");
        issue(A, 6, 3, 0, "R2 same address other index");
        issue(A ^ 22'h000001, 5, 3, 0, "R8 low bit differs");
        issue(A ^ 22'h200000, 5, 3, 0, "R8 high bit differs");
        issue(A, 5, 1, 0, "R5 misses leave first level");
        issue(A ^ 22'h200000, 5, 2, 0, "R9 second-level hit replaces first level");
        issue(A, 5, 3, 0, "R9 first-level entry replaced");
        issue(22'h0F0F0F, 1023, 3, 0, "R2 top index");
        issue(22'h0F0F0F, 0, 3, 0, "R2 wrap to index 0");
        issue(22'h0F0F0F, 1023, 2, 0, "R2 top index revisited");
        issue(22'h155555, 300, 3, 1, "R7 busy request held");
        issue(22'h155555 ^ 22'h2AAAAA, 300, 3, 0, "R7 swapped address not taken");
        issue(22'h155555 ^ 22'h2AAAAA, 300, 2, 0, "R7 swapped address now resident");

        // randomized timing, checked by the per-cycle model (R6, R7)
        for (int k = 0; k < 80; k++) begin
            logic [21:0] a;
            int t;
            a = 22'h3C0000 | 22'($urandom_range(0, 3));
            t = ($urandom_range(0, 1) == 0) ? -1 : 10 + $urandom_range(0, 1);
            issue(a, t, 0, $urandom_range(0, 1) == 1, "R6 random");
        end

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule